// File: doc/BRIEF.md
# Long-Word Write Packer with Byte Ordering

This block sits in front of a FIFO that stores only 36-bit long words. A narrower writer sends either 18-bit halves or 9-bit bytes. The block collects them into one long word. Each piece except the last is held in an auxiliary register. On the clock edge that takes the last piece, the block presents the whole long word to storage as a single push. Storage is therefore written once for each long word.

Two selections are sampled while reset is held and do not change after reset is released:
- the piece width (byte or half);
- the byte ordering, which decides whether the first piece of a long word goes to the most significant end or the least significant end.

A full signal from storage holds back the final piece until there is room. Pieces before the final one are accepted even while full is asserted.

Top module: `wpk_top`

## Requirements
- R1: `push_o` is high only in a cycle where `wr_en_i` is high, `full_i` is low and the piece counter is at the final piece. It is therefore high exactly once for each completed long word.
- R2: In a cycle with `wr_en_i` high, any piece that is not the final one is accepted and stored, and the counter advances. This happens whatever the level of `full_i`, and no push occurs.
- R3: The final piece is combined with the held pieces, and `push_o` and `push_data_o` are valid in that same cycle. At that edge the counter returns to the first piece.
- R4: In byte mode (`size_byte_i`=1 during reset), a long word is four pieces taken from `wr_data_i[8:0]`. Bits 17:9 of `wr_data_i` are ignored.
- R5: In half mode (`size_byte_i`=0 during reset), a long word is two pieces of 18 bits. Within a piece, `wr_data_i[17:9]` is the upper byte and `wr_data_i[8:0]` is the lower byte.
- R6: With `big_end_i`=1 during reset, piece k goes to the more significant end:
  - byte mode: bits [35-9k : 27-9k];
  - half mode: piece 0 goes to [35:18] and piece 1 to [17:0].
- R7: With `big_end_i`=0 during reset, piece k goes to the less significant end:
  - byte mode: bits [9k+8 : 9k];
  - half mode: piece 0 goes to [17:0] and piece 1 to [35:18].
- R8: `size_byte_i` and `big_end_i` are sampled while `rst_n` is low. Changing them after reset has no effect on packing.
- R9: Reset returns the counter to the first piece, so a partly assembled long word is discarded.
- R10: While `full_i` is high and the final piece is offered, there is no push and the counter holds. Offering the piece again once `full_i` is low pushes the correct long word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; selections sampled while low |
| size_byte_i | input | 1 | 1 = byte pieces, 0 = half pieces (sampled in reset) |
| big_end_i | input | 1 | 1 = first piece most significant (sampled in reset) |
| wr_en_i | input | 1 | Write strobe for one piece |
| wr_data_i | input | 18 | Piece data |
| full_i | input | 1 | Storage full; holds back the final piece |
| push_o | output | 1 | Write one long word into storage |
| push_data_o | output | 36 | Assembled long word |

## Verification
A wrong piece count shows up at the ports within one long word, as a push that comes one piece early or late. A wrong latched mode or a wrong ordering shows up on the first push after reset, as lanes that are swapped or missing in `push_data_o`. A corrupted auxiliary lane shows up only in the field it holds, and only at the next push. For that reason every push is compared in full against a model, both under random traffic and with mode inputs that are changed after reset.

// File: rtl/wpk_pkg.sv
package wpk_pkg;
    localparam int LANE_W     = 9;
    localparam int LANES      = 4;
    localparam int WORD_LANES = 2;
    localparam int IN_W       = LANE_W * WORD_LANES;
    localparam int LONG_W     = LANE_W * LANES;
    localparam int CNT_W      = $clog2(LANES);

    typedef struct packed {
        logic byte_mode;
        logic big_end;
    } wpk_mode_t;
endpackage

// File: rtl/wpk_count.sv
module wpk_count #(
    parameter int LANES      = wpk_pkg::LANES,
    parameter int WORD_LANES = wpk_pkg::WORD_LANES,
    parameter int CNT_W      = wpk_pkg::CNT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             byte_mode,
    input  logic             wr_en,
    input  logic             full,
    output logic [CNT_W-1:0] cnt,
    output logic             last,
    output logic             accept
);
    localparam logic [CNT_W-1:0] BYTE_LAST = CNT_W'(LANES - 1);
    localparam logic [CNT_W-1:0] WORD_LAST = CNT_W'(LANES / WORD_LANES - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_state_t;

    cnt_state_t st_d, st_q;
    logic [CNT_W-1:0] last_idx;

    always_comb begin
        st_d     = st_q;
        last_idx = byte_mode ? BYTE_LAST : WORD_LAST;
        last     = (st_q.cnt == last_idx);
        accept   = wr_en && (!last || !full);
        if (accept) begin
            st_d.cnt = last ? '0 : st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt = st_q.cnt;

    a_r2_cnt_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= last_idx);
    a_r3_wrap_after_final: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && last && !full) |=> (st_q.cnt == '0));
    a_r10_hold_while_full: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && last && full) |=> $stable(st_q.cnt));
endmodule

// File: rtl/wpk_steer.sv
module wpk_steer #(
    parameter int LANE_W     = wpk_pkg::LANE_W,
    parameter int LANES      = wpk_pkg::LANES,
    parameter int WORD_LANES = wpk_pkg::WORD_LANES,
    parameter int CNT_W      = wpk_pkg::CNT_W,
    localparam int IN_W      = LANE_W * WORD_LANES,
    localparam int LONG_W    = LANE_W * LANES
) (
    input  wpk_pkg::wpk_mode_t mode,
    input  logic [CNT_W-1:0]   cnt,
    input  logic [IN_W-1:0]    wr_data,
    output logic [LONG_W-1:0]  mask,
    output logic [LONG_W-1:0]  steered
);
    logic [CNT_W-1:0] last_idx;
    logic [CNT_W-1:0] slot;

    always_comb begin
        last_idx = mode.byte_mode ? CNT_W'(LANES - 1) : CNT_W'(LANES / WORD_LANES - 1);
        slot     = mode.big_end ? (last_idx - cnt) : cnt;
    end

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        localparam int WSLOT = l / WORD_LANES;
        localparam int SUB   = l % WORD_LANES;
        logic hit;
        logic [LANE_W-1:0] dat;
        always_comb begin
            if (mode.byte_mode) begin
                hit = (slot == CNT_W'(l));
                dat = wr_data[LANE_W-1:0];
            end else begin
                hit = (slot == CNT_W'(WSLOT));
                dat = wr_data[SUB*LANE_W +: LANE_W];
            end
        end
        assign mask[l*LANE_W +: LANE_W]    = {LANE_W{hit}};
        assign steered[l*LANE_W +: LANE_W] = dat;
    end
endmodule

// File: rtl/wpk_top.sv
module wpk_top #(
    parameter int LANE_W     = wpk_pkg::LANE_W,
    parameter int LANES      = wpk_pkg::LANES,
    parameter int WORD_LANES = wpk_pkg::WORD_LANES,
    localparam int IN_W      = LANE_W * WORD_LANES,
    localparam int LONG_W    = LANE_W * LANES,
    localparam int CNT_W     = $clog2(LANES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              size_byte_i,
    input  logic              big_end_i,
    input  logic              wr_en_i,
    input  logic [IN_W-1:0]   wr_data_i,
    input  logic              full_i,
    output logic              push_o,
    output logic [LONG_W-1:0] push_data_o
);
    typedef struct packed {
        wpk_pkg::wpk_mode_t mode;
        logic [LONG_W-1:0]  aux;
    } top_state_t;

    top_state_t st_d, st_q;
    logic [CNT_W-1:0]  cnt;
    logic              last;
    logic              accept;
    logic [LONG_W-1:0] mask;
    logic [LONG_W-1:0] steered;
    logic [LONG_W-1:0] merged;

    wpk_count #(.LANES(LANES), .WORD_LANES(WORD_LANES), .CNT_W(CNT_W)) u_count (
        .clk      (clk),
        .rst_n    (rst_n),
        .byte_mode(st_q.mode.byte_mode),
        .wr_en    (wr_en_i),
        .full     (full_i),
        .cnt      (cnt),
        .last     (last),
        .accept   (accept)
    );

    wpk_steer #(.LANE_W(LANE_W), .LANES(LANES), .WORD_LANES(WORD_LANES), .CNT_W(CNT_W)) u_steer (
        .mode   (st_q.mode),
        .cnt    (cnt),
        .wr_data(wr_data_i),
        .mask   (mask),
        .steered(steered)
    );

    always_comb begin
        st_d   = st_q;
        merged = (st_q.aux & ~mask) | (steered & mask);
        if (accept && !last) begin
            st_d.aux = merged;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.mode <= '{byte_mode: size_byte_i, big_end: big_end_i};
            st_q.aux  <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign push_o      = accept && last;
    assign push_data_o = merged;

    a_r1_push_needs_room: assert property (@(posedge clk) disable iff (!rst_n)
        push_o |-> (wr_en_i && !full_i));
    a_r8_mode_fixed: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> $stable(st_q.mode));
    a_r2_no_push_midword: assert property (@(posedge clk) disable iff (!rst_n)
        push_o |=> !push_o || st_q.mode.byte_mode == 1'b0);
    a_r3_aux_frozen_on_push: assert property (@(posedge clk) disable iff (!rst_n)
        push_o |=> $stable(st_q.aux));
endmodule

// File: tb/tb_wpk_top.sv
module tb_wpk_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        size_byte_i = 1'b1;
    logic        big_end_i = 1'b1;
    logic        wr_en_i = 1'b0;
    logic [17:0] wr_data_i = '0;
    logic        full_i = 1'b0;
    logic        push_o;
    logic [35:0] push_data_o;

    int errors = 0;
    int checks = 0;

    logic        m_byte, m_big;
    int          m_cnt;
    logic [17:0] m_pcs [4];

    always #2.5 clk = ~clk;

    wpk_top dut (
        .clk(clk), .rst_n(rst_n), .size_byte_i(size_byte_i), .big_end_i(big_end_i),
        .wr_en_i(wr_en_i), .wr_data_i(wr_data_i), .full_i(full_i),
        .push_o(push_o), .push_data_o(push_data_o)
    );

    function automatic logic [35:0] build(input logic [17:0] p0, input logic [17:0] p1,
                                          input logic [17:0] p2, input logic [17:0] p3,
                                          input logic byt, input logic big);
        logic [35:0] r = '0;
        logic [17:0] p [4];
        int n = byt ? 4 : 2;
        p[0] = p0; p[1] = p1; p[2] = p2; p[3] = p3;
        for (int k = 0; k < n; k++) begin
            int s = big ? (n - 1 - k) : k;
            if (byt) r[s*9 +: 9] = p[k][8:0];
            else     r[s*18 +: 18] = p[k];
        end
        return r;
    endfunction

    task automatic chk(input logic [35:0] act, input logic [35:0] exp, input string req);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_reset(input logic byt, input logic big);
        rst_n = 1'b0; size_byte_i = byt; big_end_i = big; wr_en_i = 1'b0; full_i = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        m_byte = byt; m_big = big; m_cnt = 0;
        for (int i = 0; i < 4; i++) m_pcs[i] = '0;
    endtask

    task automatic step(input logic en, input logic [17:0] d, input logic f, input string req);
        int  n;
        logic lastp, exp_push;
        logic [17:0] q [4];
        wr_en_i = en; wr_data_i = d; full_i = f;
        #1;
        n = m_byte ? 4 : 2;
        lastp = (m_cnt == n - 1);
        exp_push = en && lastp && !f;
        chk({35'd0, push_o}, {35'd0, exp_push}, req);
        if (exp_push) begin
            for (int i = 0; i < 4; i++) q[i] = m_pcs[i];
            q[m_cnt] = d;
            chk(push_data_o, build(q[0], q[1], q[2], q[3], m_byte, m_big),
                m_byte ? (m_big ? "R3 R4 R6" : "R3 R4 R7") : (m_big ? "R3 R5 R6" : "R3 R5 R7"));
        end
        @(posedge clk);
        if (en && (!lastp || !f)) begin
            m_pcs[m_cnt] = d;
            m_cnt = lastp ? 0 : m_cnt + 1;
        end
        @(negedge clk);
    endtask

    initial begin
        #800000;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [31:0] seed;
        seed = $urandom(32'h5eed_1234);
        @(negedge clk);

        // R9: reset state, no push on first piece
        do_reset(1'b1, 1'b1);
        step(1'b1, 18'h3_ff01, 1'b0, "R9 reset");

        // R9: partial word discarded by reset
        do_reset(1'b1, 1'b0);
        step(1'b1, 18'h0_0011, 1'b0, "R9");
        step(1'b1, 18'h0_0022, 1'b0, "R9");
        do_reset(1'b1, 1'b0);
        for (int i = 0; i < 4; i++) step(1'b1, 18'(i + 5), 1'b0, "R9 R2");

        // R10: final piece held while full, pre-final accepted while full (R2)
        do_reset(1'b1, 1'b1);
        step(1'b1, 18'h0_0a1, 1'b1, "R2");
        step(1'b1, 18'h0_0b2, 1'b1, "R2");
        step(1'b1, 18'h0_0c3, 1'b1, "R2");
        for (int i = 0; i < 3; i++) step(1'b1, 18'h0_0d4, 1'b1, "R10");
        step(1'b1, 18'h0_0d4, 1'b0, "R10");

        // R8: mode inputs changed after reset are ignored
        do_reset(1'b1, 1'b1);
        size_byte_i = 1'b0; big_end_i = 1'b0;
        for (int i = 0; i < 4; i++) step(1'b1, 18'h3_fe00 | 18'(i * 17), 1'b0, "R8");
        do_reset(1'b0, 1'b0);
        size_byte_i = 1'b1; big_end_i = 1'b1;
        step(1'b1, 18'h2_4681, 1'b0, "R8 R5");
        step(1'b1, 18'h1_3579, 1'b0, "R8 R5");

        // Random traffic in every mode; R4 upper bits random in byte mode
        for (int m = 0; m < 4; m++) begin
            do_reset(m[1], m[0]);
            for (int i = 0; i < 400; i++) begin
                size_byte_i = 1'($urandom);
                big_end_i   = 1'($urandom);
                step(1'($urandom_range(0, 3) != 0), 18'($urandom),
                     1'($urandom_range(0, 3) == 0), "R1 R2");
            end
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule